// File: doc/BRIEF.md
# Two-Port Burst-Addressed Synchronous RAM

A shared word store with two equal ports, A and B, that can each read or write any location in the same clock cycle, the same location included. Every word is 18 bits wide and is stored as two 9-bit lanes. Each lane can be enabled on its own for writes and for reads. The depth is set by the address width parameter. The default is 12 bits, which gives 4096 words. A width of 13 gives 8192 words.

Each port holds its address in a counter register. A clear, a load or a step on that counter sets the address for the current access, so a burst can walk through memory without a new address on every cycle. A static mode input on each port selects how read data is delivered. In flow-through mode the data comes from the array's read register. In pipelined mode it passes through one more register and appears one cycle later.

A port takes part in an access only when it is selected: its active-low select must be low and its active-high select must be high. A read also needs the active-low output enable. Both ports run on one common clock, which is what allows collisions between them to be resolved exactly. The reset is synchronous and active high. It returns the counters and the output stages to zero, blocks writes, and leaves the array contents as they are.

Top module: `dual_port_burst_ram`

## Requirements
- R1: The array holds 2**ADDR_W independent 18-bit words (4096 by default), and each port can reach every one of them.
- R2: The address used on a clock edge is chosen in this order: clear gives 0, else load gives the address input, else step gives the counter plus one, else the counter holds. The counter then keeps that address.
- R3: Stepping from the last address (2**ADDR_W-1) gives address 0.
- R4: With the mode input low (flow-through), data read at edge k is valid at the outputs after edge k.
- R5: With the mode input high (pipelined), data read at edge k is valid at the outputs after edge k+1.
- R6: A port is selected only when its active-low select is 0 and its active-high select is 1. An unselected port writes nothing and returns no read data.
- R7: When the read/write input is 0 (write), only lanes whose active-low lane bit is 0 are written. Lane bit 1 controls data bits 17:9 and lane bit 0 controls bits 8:0.
- R8: On a read, lanes whose lane bit is 1 return zeros, and enabled lanes return the stored data.
- R9: A read happens only when the read/write input is 1 and the active-low output enable is 0. In all other cases the valid flag stays low.
- R10: When both ports write the same address in the same cycle, port A's data is stored in every lane that A enables. Port B's data is stored only in the lanes that A leaves disabled.
- R11: A read on one port that hits the address being written by the other port in the same cycle returns the data stored before that write.
- R12: Whenever the valid flag is low, the read data is all zeros.
- R13: While reset is high, and on the first cycle after it, both outputs are zero and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_rnw | input | 1 | Port A: 1 read, 0 write |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_lane_n | input | 2 | Port A lane enables, active low (bit 1 upper) |
| a_clear | input | 1 | Port A counter clear |
| a_load | input | 1 | Port A counter load from a_addr |
| a_step | input | 1 | Port A counter increment |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | 18 | Port A write data |
| a_pipe | input | 1 | Port A mode: 1 pipelined, 0 flow-through |
| a_rdata | output | 18 | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_rnw | input | 1 | Port B: 1 read, 0 write |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_lane_n | input | 2 | Port B lane enables, active low (bit 1 upper) |
| b_clear | input | 1 | Port B counter clear |
| b_load | input | 1 | Port B counter load from b_addr |
| b_step | input | 1 | Port B counter increment |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | 18 | Port B write data |
| b_pipe | input | 1 | Port B mode: 1 pipelined, 0 flow-through |
| b_rdata | output | 18 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The properties assume that every control input is known (never X) at each rising edge once reset has been released, and that reset is held for at least one edge at start-up. They do not assume the mode inputs stay fixed, so mode changes made in the middle of a read stream are allowed. The stimulus changes inputs only on falling edges and holds reset for three cycles at the start. Before any read is issued, it writes every word, so the array never returns unknown data. The final randomized phase keeps both ports' addresses within a small window, which makes same-address collisions and read-under-write cases happen often.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int LANES  = 2;
  localparam int NPORTS = 2;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_STEP,
    OP_LOAD,
    OP_CLEAR
  } ctr_op_e;

  // Clear beats load, load beats step.
  function automatic ctr_op_e pick_op(input logic clr, input logic ld, input logic st);
    if (clr)     return OP_CLEAR;
    else if (ld) return OP_LOAD;
    else if (st) return OP_STEP;
    return OP_HOLD;
  endfunction

endpackage

// File: rtl/dpr_burst_counter.sv
module dpr_burst_counter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] ptr_q
);

  // Address for this edge's access; the counter keeps it afterwards.
  always_comb begin
    unique case (pick_op(clear, load, step))
      OP_CLEAR: acc_addr = '0;
      OP_LOAD:  acc_addr = base;
      OP_STEP:  acc_addr = ptr_q + 1'b1;
      default:  acc_addr = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= acc_addr;
  end

endmodule

// File: rtl/dpr_lane_ram.sv
module dpr_lane_ram #(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [LANE_W-1:0] din_a,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [LANE_W-1:0] din_b,
  output logic [LANE_W-1:0] q_a,
  output logic [LANE_W-1:0] q_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];

  // Port A's write is issued last, so it wins on a shared address.
  // Reads sample the contents from before this edge.
  always_ff @(posedge clk) begin
    if (we_b) cells[addr_b] <= din_b;
    if (we_a) cells[addr_a] <= din_a;
    q_a <= cells[addr_a];
    q_b <= cells[addr_b];
  end

endmodule

// File: rtl/dpr_read_port.sv
module dpr_read_port
  import dpr_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_req,
  input  logic [LANES-1:0]        lane_on,
  input  logic                    pipe,
  input  logic [LANES*LANE_W-1:0] ram_q,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int WORD_W = LANES * LANE_W;

  logic              v1_q, v2_q;
  logic [LANES-1:0]  on1_q;
  logic [WORD_W-1:0] ft_d, d2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q  <= 1'b0;
      on1_q <= '0;
      v2_q  <= 1'b0;
      d2_q  <= '0;
    end else begin
      v1_q  <= rd_req;
      on1_q <= lane_on;
      v2_q  <= v1_q;
      d2_q  <= ft_d;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign ft_d[l*LANE_W +: LANE_W] = (v1_q && on1_q[l]) ? ram_q[l*LANE_W +: LANE_W] : '0;
  end

  assign rdata  = pipe ? d2_q : ft_d;
  assign rvalid = pipe ? v2_q : v1_q;

endmodule

// File: rtl/dual_port_burst_ram.sv
module dual_port_burst_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    a_cs_n,
  input  logic                    a_cs,
  input  logic                    a_rnw,
  input  logic                    a_oe_n,
  input  logic [LANES-1:0]        a_lane_n,
  input  logic                    a_clear,
  input  logic                    a_load,
  input  logic                    a_step,
  input  logic [ADDR_W-1:0]       a_addr,
  input  logic [LANES*LANE_W-1:0] a_wdata,
  input  logic                    a_pipe,
  output logic [LANES*LANE_W-1:0] a_rdata,
  output logic                    a_rvalid,
  input  logic                    b_cs_n,
  input  logic                    b_cs,
  input  logic                    b_rnw,
  input  logic                    b_oe_n,
  input  logic [LANES-1:0]        b_lane_n,
  input  logic                    b_clear,
  input  logic                    b_load,
  input  logic                    b_step,
  input  logic [ADDR_W-1:0]       b_addr,
  input  logic [LANES*LANE_W-1:0] b_wdata,
  input  logic                    b_pipe,
  output logic [LANES*LANE_W-1:0] b_rdata,
  output logic                    b_rvalid
);

  localparam int WORD_W = LANES * LANE_W;

  logic [NPORTS-1:0] cs_n, cs, rnw, oe_n, clr, ld, st, pipe;
  logic [NPORTS-1:0] sel, rd_req, rv;
  logic [LANES-1:0]  lane_n  [NPORTS];
  logic [LANES-1:0]  wr_lane [NPORTS];
  logic [ADDR_W-1:0] base    [NPORTS];
  logic [ADDR_W-1:0] acc     [NPORTS];
  logic [ADDR_W-1:0] ptr_q   [NPORTS];
  logic [WORD_W-1:0] wd      [NPORTS];
  logic [WORD_W-1:0] ram_q   [NPORTS];
  logic [WORD_W-1:0] rd      [NPORTS];

  assign cs_n = {b_cs_n,  a_cs_n};
  assign cs   = {b_cs,    a_cs};
  assign rnw  = {b_rnw,   a_rnw};
  assign oe_n = {b_oe_n,  a_oe_n};
  assign clr  = {b_clear, a_clear};
  assign ld   = {b_load,  a_load};
  assign st   = {b_step,  a_step};
  assign pipe = {b_pipe,  a_pipe};

  assign lane_n[0] = a_lane_n;
  assign lane_n[1] = b_lane_n;
  assign base[0]   = a_addr;
  assign base[1]   = b_addr;
  assign wd[0]     = a_wdata;
  assign wd[1]     = b_wdata;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign sel[p]     = !cs_n[p] && cs[p];
    assign rd_req[p]  = sel[p] && rnw[p] && !oe_n[p];
    assign wr_lane[p] = (sel[p] && !rnw[p] && !rst) ? ~lane_n[p] : '0;

    dpr_burst_counter #(.ADDR_W(ADDR_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .clear    (clr[p]),
      .load     (ld[p]),
      .step     (st[p]),
      .base     (base[p]),
      .acc_addr (acc[p]),
      .ptr_q    (ptr_q[p])
    );

    dpr_read_port #(.LANE_W(LANE_W)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .rd_req  (rd_req[p]),
      .lane_on (~lane_n[p]),
      .pipe    (pipe[p]),
      .ram_q   (ram_q[p]),
      .rdata   (rd[p]),
      .rvalid  (rv[p])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dpr_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk    (clk),
      .we_a   (wr_lane[0][l]),
      .addr_a (acc[0]),
      .din_a  (wd[0][l*LANE_W +: LANE_W]),
      .we_b   (wr_lane[1][l]),
      .addr_b (acc[1]),
      .din_b  (wd[1][l*LANE_W +: LANE_W]),
      .q_a    (ram_q[0][l*LANE_W +: LANE_W]),
      .q_b    (ram_q[1][l*LANE_W +: LANE_W])
    );
  end

  assign a_rdata  = rd[0];
  assign a_rvalid = rv[0];
  assign b_rdata  = rd[1];
  assign b_rvalid = rv[1];

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              a_cs_n,
  input logic              a_cs,
  input logic              a_rnw,
  input logic              a_oe_n,
  input logic              a_clear,
  input logic              a_load,
  input logic              a_step,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_pipe,
  input logic [2*LANE_W-1:0] a_rdata,
  input logic              a_rvalid,
  input logic [ADDR_W-1:0] a_ptr,
  input logic              b_cs_n,
  input logic              b_cs,
  input logic              b_rnw,
  input logic              b_oe_n,
  input logic              b_clear,
  input logic              b_load,
  input logic              b_step,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_pipe,
  input logic [2*LANE_W-1:0] b_rdata,
  input logic              b_rvalid,
  input logic [ADDR_W-1:0] b_ptr
);

  logic a_req, b_req;
  assign a_req = !a_cs_n && a_cs && a_rnw && !a_oe_n;
  assign b_req = !b_cs_n && b_cs && b_rnw && !b_oe_n;

  // Counter ordering and wrap (R2, R3)
  p_a_clear_r2: assert property (@(posedge clk) disable iff (rst) a_clear |=> a_ptr == '0);
  p_b_clear_r2: assert property (@(posedge clk) disable iff (rst) b_clear |=> b_ptr == '0);
  p_a_load_r2:  assert property (@(posedge clk) disable iff (rst) (!a_clear && a_load) |=> a_ptr == $past(a_addr));
  p_b_load_r2:  assert property (@(posedge clk) disable iff (rst) (!b_clear && b_load) |=> b_ptr == $past(b_addr));
  p_a_step_r3:  assert property (@(posedge clk) disable iff (rst) (!a_clear && !a_load && a_step) |=> a_ptr == $past(a_ptr) + 1'b1);
  p_b_step_r3:  assert property (@(posedge clk) disable iff (rst) (!b_clear && !b_load && b_step) |=> b_ptr == $past(b_ptr) + 1'b1);
  p_a_hold_r2:  assert property (@(posedge clk) disable iff (rst) (!a_clear && !a_load && !a_step) |=> $stable(a_ptr));
  p_b_hold_r2:  assert property (@(posedge clk) disable iff (rst) (!b_clear && !b_load && !b_step) |=> $stable(b_ptr));

  // Read latency per mode (R4, R5, R9)
  p_a_ft_r4:    assert property (@(posedge clk) disable iff (rst) a_req |=> (a_pipe || a_rvalid));
  p_b_ft_r4:    assert property (@(posedge clk) disable iff (rst) b_req |=> (b_pipe || b_rvalid));
  p_a_noft_r9:  assert property (@(posedge clk) disable iff (rst) !a_req |=> (a_pipe || !a_rvalid));
  p_b_noft_r9:  assert property (@(posedge clk) disable iff (rst) !b_req |=> (b_pipe || !b_rvalid));
  p_a_pipe_r5:  assert property (@(posedge clk) disable iff (rst) a_req |=> ##1 (!a_pipe || a_rvalid));
  p_b_pipe_r5:  assert property (@(posedge clk) disable iff (rst) b_req |=> ##1 (!b_pipe || b_rvalid));
  p_a_nopp_r9:  assert property (@(posedge clk) disable iff (rst) !a_req |=> ##1 (!a_pipe || !a_rvalid));
  p_b_nopp_r9:  assert property (@(posedge clk) disable iff (rst) !b_req |=> ##1 (!b_pipe || !b_rvalid));

  // Idle output is zero (R12)
  p_a_zero_r12: assert property (@(posedge clk) disable iff (rst) !a_rvalid |-> a_rdata == '0);
  p_b_zero_r12: assert property (@(posedge clk) disable iff (rst) !b_rvalid |-> b_rdata == '0);

endmodule

bind dual_port_burst_ram dpr_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_cs_n   (a_cs_n),
  .a_cs     (a_cs),
  .a_rnw    (a_rnw),
  .a_oe_n   (a_oe_n),
  .a_clear  (a_clear),
  .a_load   (a_load),
  .a_step   (a_step),
  .a_addr   (a_addr),
  .a_pipe   (a_pipe),
  .a_rdata  (a_rdata),
  .a_rvalid (a_rvalid),
  .a_ptr    (ptr_q[0]),
  .b_cs_n   (b_cs_n),
  .b_cs     (b_cs),
  .b_rnw    (b_rnw),
  .b_oe_n   (b_oe_n),
  .b_clear  (b_clear),
  .b_load   (b_load),
  .b_step   (b_step),
  .b_addr   (b_addr),
  .b_pipe   (b_pipe),
  .b_rdata  (b_rdata),
  .b_rvalid (b_rvalid),
  .b_ptr    (ptr_q[1])
);

// File: tb/test_dual_port_burst_ram.sv
module test_dual_port_burst_ram;

  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0]  cs_n, cs, rnw, oe_n, clr, ld, st, pipe;
  logic [1:0]  lane_n [2];
  logic [AW-1:0] addr [2];
  logic [17:0] wdata  [2];
  logic [17:0] a_rdata, b_rdata;
  logic        a_rvalid, b_rvalid;

  dual_port_burst_ram #(.ADDR_W(AW), .LANE_W(9)) i_dual_port_burst_ram (
    .clk(clk), .rst(rst),
    .a_cs_n(cs_n[0]), .a_cs(cs[0]), .a_rnw(rnw[0]), .a_oe_n(oe_n[0]), .a_lane_n(lane_n[0]),
    .a_clear(clr[0]), .a_load(ld[0]), .a_step(st[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
    .a_pipe(pipe[0]), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_cs_n(cs_n[1]), .b_cs(cs[1]), .b_rnw(rnw[1]), .b_oe_n(oe_n[1]), .b_lane_n(lane_n[1]),
    .b_clear(clr[1]), .b_load(ld[1]), .b_step(st[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
    .b_pipe(pipe[1]), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R13";

  // Behavioural reference state
  logic [17:0]   m_mem [DEPTH];
  logic [AW-1:0] m_ptr [2];
  logic [17:0]   m_d1 [2], m_d2 [2];
  logic          m_v1 [2], m_v2 [2];

  function automatic logic [17:0] pat(input int k);
    return 18'((k * 2731) ^ 18'h15a5a);
  endfunction

  task automatic model_step();
    logic [AW-1:0] eff [2];
    logic [17:0]   ftd [2];
    logic          ftv [2];
    logic          selp;
    for (int p = 0; p < 2; p++) begin
      if (rst) begin
        m_ptr[p] = '0; m_v1[p] = 1'b0; m_v2[p] = 1'b0; m_d1[p] = '0; m_d2[p] = '0;
      end else begin
        if (clr[p])     eff[p] = '0;
        else if (ld[p]) eff[p] = addr[p];
        else if (st[p]) eff[p] = AW'((int'(m_ptr[p]) + 1) % DEPTH);
        else            eff[p] = m_ptr[p];
        m_ptr[p] = eff[p];
        selp   = !cs_n[p] && cs[p];
        ftv[p] = selp && rnw[p] && !oe_n[p];
        ftd[p] = '0;
        for (int l = 0; l < 2; l++)
          if (ftv[p] && !lane_n[p][l]) ftd[p][l*9 +: 9] = m_mem[eff[p]][l*9 +: 9];
      end
    end
    if (!rst) begin
      for (int p = 1; p >= 0; p--) begin
        if (!cs_n[p] && cs[p] && !rnw[p])
          for (int l = 0; l < 2; l++)
            if (!lane_n[p][l]) m_mem[eff[p]][l*9 +: 9] = wdata[p][l*9 +: 9];
      end
      for (int p = 0; p < 2; p++) begin
        m_d2[p] = m_d1[p]; m_v2[p] = m_v1[p];
        m_d1[p] = ftd[p];  m_v1[p] = ftv[p];
      end
    end
  endtask

  task automatic check(input bit ok, input string what, input logic [18:0] act, input logic [18:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [18:0] ea, eb;
    ea = pipe[0] ? {m_v2[0], m_d2[0]} : {m_v1[0], m_d1[0]};
    eb = pipe[1] ? {m_v2[1], m_d2[1]} : {m_v1[1], m_d1[1]};
    check({a_rvalid, a_rdata} === ea, "port A {valid,data}", {a_rvalid, a_rdata}, ea);
    check({b_rvalid, b_rdata} === eb, "port B {valid,data}", {b_rvalid, b_rdata}, eb);
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int p);
    cs_n[p] = 1'b1; cs[p] = 1'b0; rnw[p] = 1'b1; oe_n[p] = 1'b1; lane_n[p] = 2'b11;
    clr[p] = 1'b0; ld[p] = 1'b0; st[p] = 1'b0; addr[p] = '0; wdata[p] = '0;
  endtask

  task automatic drive(input int p, input logic rd, input logic oen, input logic [1:0] ln,
                       input logic c, input logic l, input logic s,
                       input logic [AW-1:0] ad, input logic [17:0] wd);
    cs_n[p] = 1'b0; cs[p] = 1'b1; rnw[p] = rd; oe_n[p] = oen; lane_n[p] = ln;
    clr[p] = c; ld[p] = l; st[p] = s; addr[p] = ad; wdata[p] = wd;
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    pipe = 2'b00;
    idle(0); idle(1);
    // R13: reset state
    for (int i = 0; i < 3; i++) tick();
    rst = 1'b0;
    tick();
    check({a_rvalid, a_rdata, b_rvalid, b_rdata} == '0, "outputs after reset", {a_rvalid, a_rdata}, '0);

    // R1: fill every word through one burst
    cur_req = "R1";
    drive(0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, '0, pat(0));
    tick();
    for (int k = 1; k < DEPTH; k++) begin
      drive(0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, '0, pat(k));
      tick();
    end
    // R3: step past the top wraps to 0; flow-through read
    cur_req = "R3";
    for (int i = 0; i < 3; i++) begin
      drive(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, '0, '0);
      tick();
    end
    idle(0); tick();

    // R4: flow-through burst on B
    cur_req = "R4";
    drive(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd100, '0); tick();
    for (int i = 0; i < 5; i++) begin
      drive(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, '0, '0); tick();
    end
    idle(1); tick(); tick();

    // R5: pipelined burst on A crossing the top address
    cur_req = "R5";
    pipe[0] = 1'b1; tick();
    drive(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd4090, '0); tick();
    for (int i = 0; i < 8; i++) begin
      drive(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, '0, '0); tick();
    end
    idle(0); tick(); tick(); tick();
    pipe[0] = 1'b0; tick();

    // R2: counter ordering
    cur_req = "R2";
    drive(0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 12'd55, '0); tick();
    drive(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 12'd55, '0); tick();
    drive(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 12'd9, '0);  tick();
    drive(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 12'd9, '0);  tick();
    idle(0); tick();

    // R6: deselected writes leave memory untouched
    cur_req = "R6";
    drive(1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 12'd200, 18'h2aaaa); cs_n[1] = 1'b1; tick();
    drive(1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 12'd201, 18'h15555); cs[1] = 1'b0; tick();
    drive(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd200, '0); cs[1] = 1'b0; tick();
    drive(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd200, '0); tick();
    drive(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, '0, '0); tick();
    idle(1); tick();

    // R7 / R8: lane writes and lane-masked reads
    cur_req = "R7";
    drive(0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 12'd300, 18'h3ffff);
    drive(1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 12'd301, 18'h3ffff); tick();
    drive(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd300, '0);
    drive(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd301, '0); tick();
    cur_req = "R8";
    drive(0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 12'd301, '0);
    drive(1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 12'd300, '0); tick();
    idle(0); idle(1); tick();

    // R9: output enable and write cycles give no read data
    cur_req = "R9";
    drive(0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 12'd300, '0); tick();
    drive(0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 12'd302, 18'h12345); tick();
    idle(0); tick();

    // R10: same-address double write
    cur_req = "R10";
    drive(0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 12'd400, 18'h00011);
    drive(1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 12'd400, 18'h3fe22); tick();
    drive(0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 12'd401, 18'h0aaaa);
    drive(1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 12'd401, 18'h05555); tick();
    drive(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd400, '0);
    drive(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd401, '0); tick();
    idle(0); idle(1); tick();

    // R11: read under write returns the old word
    cur_req = "R11";
    drive(0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 12'd500, 18'h1beef);
    drive(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 12'd500, '0); tick();
    idle(0); tick();
    idle(1); tick();

    // R12: idle ports
    cur_req = "R12";
    for (int i = 0; i < 3; i++) tick();

    // Random mix of all controls, focused on a small window (R10)
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < 2; p++) begin
        cs_n[p]   = ($urandom_range(0, 7) == 0);
        cs[p]     = ($urandom_range(0, 7) != 0);
        rnw[p]    = $urandom_range(0, 1) != 0;
        oe_n[p]   = ($urandom_range(0, 5) == 0);
        lane_n[p] = 2'($urandom_range(0, 3));
        clr[p]    = ($urandom_range(0, 15) == 0);
        ld[p]     = ($urandom_range(0, 3) == 0);
        st[p]     = $urandom_range(0, 1) != 0;
        addr[p]   = AW'($urandom_range(0, 7));
        wdata[p]  = 18'($urandom);
        if (i % 97 == 0) pipe[p] = $urandom_range(0, 1) != 0;
      end
      tick();
    end
    idle(0); idle(1); tick(); tick();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule